// File: doc/BRIEF.md
# Audio Bit and Frame Clock Generator

This block produces the serial bit clock and the two word-select (frame) clocks of a stereo serial audio port. It runs entirely in the master-clock domain. A programmable divider turns the master clock into the bit clock. Two further counters each count bit periods and produce a transmit word-select and a receive word-select, each with its own frame length. Alongside the clocks, the block raises one-cycle strobes that tell a serializer when a bit period ends and when a frame ends.

In master mode the block drives the clocks out and raises the pad drive enable. In slave mode it lowers the drive enable and takes the bit clock and both word-selects from the pins instead. Each of these inputs passes through a two-flop synchronizer, and the strobes are derived from edges of the synchronized copies. The bit clock can be inverted. A sharing field can tie both frame outputs to a single counter.

Divider values are loaded into shadow registers only at a frame boundary, so a change made on the fly never shortens a clock phase mid-period. The strobes are plain pulses with no back-pressure: a serializer must accept each one in the cycle it appears.

Top module: `audio_clkgen`

## Requirements
- R1: With master divider D > 0, one bit period lasts D+1 master cycles. `bclk_o` is low for the first floor((D+1)/2) cycles of the period and high for the rest. `bit_stb` is high for exactly the last cycle of each period.
- R2: When the active master divider is 0, `bclk_o` is the master clock itself (high while `clk` is high) and `bit_stb` is high in every cycle.
- R3: With transmit divider F, the transmit frame is F+1 bit periods long. `tx_ws_o` is 0 for the first floor((F+1)/2) bits and 1 for the rest. `tx_frame_stb` is high only in the `bit_stb` cycle of the frame's last bit.
- R4: With `cfg_share` at 0 or 3, the receive frame is timed by its own divider in the same way as R3, independently of the transmit frame.
- R5: With `cfg_share` = 1, `rx_ws_o` and `rx_frame_stb` copy the transmit outputs. With `cfg_share` = 2, `tx_ws_o` and `tx_frame_stb` copy the receive outputs.
- R6: A new frame divider value takes effect only when that frame wraps. A new master divider value takes effect only at a bit-period end that is also a transmit-counter frame wrap.
- R7: `cfg_bclk_inv` = 1 inverts `bclk_o` in master mode. In slave mode it inverts the external bit clock before synchronization, so `bit_stb` marks rising edges of the inverted clock.
- R8: With `cfg_slave` = 1, `bclk_o`, `tx_ws_o` and `rx_ws_o` are the pin inputs delayed by two master cycles. `bit_stb` is high in the first cycle in which the delayed bit clock is high. A frame strobe is high in the first cycle in which the delayed word-select is low after having been high.
- R9: `clk_oe` is 1 in master mode and 0 in slave mode.
- R10: A synchronous reset (`rst_n` = 0) clears the counters and synchronizers and loads all three shadow dividers from the configuration inputs, so that a bit period and both frames start together when reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mdiv | input | 8 | Master cycles per bit period minus one |
| cfg_tx_div | input | 8 | Bits per transmit frame minus one |
| cfg_rx_div | input | 8 | Bits per receive frame minus one |
| cfg_slave | input | 1 | 1: clocks come from pins; 0: generated |
| cfg_bclk_inv | input | 1 | Invert the bit clock |
| cfg_share | input | 2 | Frame sharing: 0/3 independent, 1 rx follows tx, 2 tx follows rx |
| ext_bclk | input | 1 | External bit clock (slave mode) |
| ext_tx_ws | input | 1 | External transmit word-select (slave mode) |
| ext_rx_ws | input | 1 | External receive word-select (slave mode) |
| bclk_o | output | 1 | Bit clock |
| tx_ws_o | output | 1 | Transmit word-select |
| rx_ws_o | output | 1 | Receive word-select |
| clk_oe | output | 1 | Pad drive enable for the clock pins |
| bit_stb | output | 1 | One-cycle bit-period strobe |
| tx_frame_stb | output | 1 | One-cycle transmit frame-end strobe |
| rx_frame_stb | output | 1 | One-cycle receive frame-end strobe |

## Verification
The embedded properties check several rules on every cycle. The bit clock is low right after each period end. A word-select is low right after each frame wrap. No shadow divider moves except at its boundary. Slave edge strobes never last two cycles, and a master frame strobe always coincides with a bit strobe. Exact period lengths, duty split, the clock pass-through, sharing, inversion, synchronizer latency and the deferred effect of a divider change mid-frame can only be shown by the bench's scenarios. Those scenarios compare every output each cycle against a behavioural model.

// File: rtl/audio_clkgen_pkg.sv
package audio_clkgen_pkg;
  typedef enum logic [1:0] {
    SHARE_OFF     = 2'd0,
    SHARE_RX_ON_TX = 2'd1,
    SHARE_TX_ON_RX = 2'd2,
    SHARE_OFF_ALT = 2'd3
  } share_e;
  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/aclk_bit_div.sv
module aclk_bit_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_cfg,
  input  logic             reload,
  output logic             bit_end,
  output logic             bypass,
  output logic             bclk_q
);
  logic [DIV_W-1:0] cnt, cnt_n, shd, shd_n;
  logic [DIV_W:0]   low_n;

  assign bit_end = (cnt == shd);
  assign bypass  = (shd == '0);

  always_comb begin
    if (!rst_n) begin
      cnt_n = '0;
      shd_n = div_cfg;
    end else if (bit_end) begin
      cnt_n = '0;
      shd_n = reload ? div_cfg : shd;
    end else begin
      cnt_n = cnt + 1'b1;
      shd_n = shd;
    end
    low_n = ({1'b0, shd_n} + (DIV_W+1)'(1)) >> 1;
  end

  always_ff @(posedge clk) begin
    cnt    <= cnt_n;
    shd    <= shd_n;
    bclk_q <= ({1'b0, cnt_n} >= low_n);
  end

  // R1: a new period always opens with the low phase
  assert_low_after_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_end && !reload && shd != '0) |=> !bclk_q);
  // R6: the master shadow only moves at a period end
  assert_mdiv_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_end |=> $stable(shd));
endmodule

// File: rtl/aclk_frame_div.sv
module aclk_frame_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_cfg,
  input  logic             step,
  output logic             frame_end,
  output logic             ws_q
);
  logic [DIV_W-1:0] cnt, cnt_n, shd, shd_n;
  logic [DIV_W:0]   half_n;

  assign frame_end = step && (cnt == shd);

  always_comb begin
    cnt_n = cnt;
    shd_n = shd;
    if (!rst_n) begin
      cnt_n = '0;
      shd_n = div_cfg;
    end else if (frame_end) begin
      cnt_n = '0;
      shd_n = div_cfg;
    end else if (step) begin
      cnt_n = cnt + 1'b1;
    end
    half_n = ({1'b0, shd_n} + (DIV_W+1)'(1)) >> 1;
  end

  always_ff @(posedge clk) begin
    cnt  <= cnt_n;
    shd  <= shd_n;
    ws_q <= ({1'b0, cnt_n} >= half_n);
  end

  // R3: each frame starts in the low half
  assert_ws_low_at_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && div_cfg != '0) |=> !ws_q);
  // R6: the frame shadow only moves at a wrap
  assert_fdiv_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(shd));
endmodule

// File: rtl/aclk_edge_sync.sv
module aclk_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  localparam int unsigned LEN = STAGES + 1;
  logic [LEN-1:0] pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[LEN-2:0], din};
  end

  assign level = pipe[STAGES-1];
  assign rise  = pipe[STAGES-1] & ~pipe[STAGES];
  assign fall  = ~pipe[STAGES-1] & pipe[STAGES];

  // R8: edge strobes last one cycle
  assert_rise_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
  assert_fall_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import audio_clkgen_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_mdiv,
  input  logic [DIV_W-1:0] cfg_tx_div,
  input  logic [DIV_W-1:0] cfg_rx_div,
  input  logic             cfg_slave,
  input  logic             cfg_bclk_inv,
  input  logic [1:0]       cfg_share,
  input  logic             ext_bclk,
  input  logic             ext_tx_ws,
  input  logic             ext_rx_ws,
  output logic             bclk_o,
  output logic             tx_ws_o,
  output logic             rx_ws_o,
  output logic             clk_oe,
  output logic             bit_stb,
  output logic             tx_frame_stb,
  output logic             rx_frame_stb
);
  localparam int unsigned NPIN = 3;

  logic m_bit_end, m_bypass, m_bclk;
  logic m_tx_end, m_tx_ws, m_rx_end, m_rx_ws;
  logic [NPIN-1:0] pin_in, s_lvl, s_rise, s_fall;
  logic tx_ws_src, tx_end_src, rx_ws_src, rx_end_src;
  share_e share;

  aclk_bit_div #(.DIV_W(DIV_W)) u_bit (
    .clk(clk), .rst_n(rst_n), .div_cfg(cfg_mdiv), .reload(m_tx_end),
    .bit_end(m_bit_end), .bypass(m_bypass), .bclk_q(m_bclk));

  aclk_frame_div #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .div_cfg(cfg_tx_div), .step(m_bit_end),
    .frame_end(m_tx_end), .ws_q(m_tx_ws));

  aclk_frame_div #(.DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .div_cfg(cfg_rx_div), .step(m_bit_end),
    .frame_end(m_rx_end), .ws_q(m_rx_ws));

  assign pin_in = {ext_rx_ws, ext_tx_ws, ext_bclk ^ cfg_bclk_inv};

  for (genvar g = 0; g < NPIN; g++) begin : g_sync
    aclk_edge_sync #(.STAGES(SYNC_DEPTH)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(pin_in[g]),
      .level(s_lvl[g]), .rise(s_rise[g]), .fall(s_fall[g]));
  end

  assign share      = share_e'(cfg_share);
  assign tx_ws_src  = cfg_slave ? s_lvl[1]  : m_tx_ws;
  assign tx_end_src = cfg_slave ? s_fall[1] : m_tx_end;
  assign rx_ws_src  = cfg_slave ? s_lvl[2]  : m_rx_ws;
  assign rx_end_src = cfg_slave ? s_fall[2] : m_rx_end;

  always_comb begin
    tx_ws_o      = tx_ws_src;
    tx_frame_stb = tx_end_src;
    rx_ws_o      = rx_ws_src;
    rx_frame_stb = rx_end_src;
    case (share)
      SHARE_RX_ON_TX: begin
        rx_ws_o      = tx_ws_src;
        rx_frame_stb = tx_end_src;
      end
      SHARE_TX_ON_RX: begin
        tx_ws_o      = rx_ws_src;
        tx_frame_stb = rx_end_src;
      end
      default: ;
    endcase
  end

  assign bclk_o  = cfg_slave ? s_lvl[0]
                 : ((m_bypass ? clk : m_bclk) ^ cfg_bclk_inv);
  assign bit_stb = cfg_slave ? s_rise[0] : m_bit_end;
  assign clk_oe  = ~cfg_slave;

  // R3: in master mode a frame end always lands on a bit end
  assert_frame_on_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_slave && m_tx_end) |-> bit_stb);
endmodule

// File: tb/tb_audio_clkgen.sv
module tb_audio_clkgen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cfg_mdiv = 8'd3, cfg_tx_div = 8'd15, cfg_rx_div = 8'd9;
  logic cfg_slave = 1'b0, cfg_bclk_inv = 1'b0;
  logic [1:0] cfg_share = 2'd0;
  logic ext_bclk = 1'b0, ext_tx_ws = 1'b0, ext_rx_ws = 1'b0;
  logic bclk_o, tx_ws_o, rx_ws_o, clk_oe, bit_stb, tx_frame_stb, rx_frame_stb;

  audio_clkgen dut (
    .clk(clk), .rst_n(rst_n), .cfg_mdiv(cfg_mdiv), .cfg_tx_div(cfg_tx_div),
    .cfg_rx_div(cfg_rx_div), .cfg_slave(cfg_slave), .cfg_bclk_inv(cfg_bclk_inv),
    .cfg_share(cfg_share), .ext_bclk(ext_bclk), .ext_tx_ws(ext_tx_ws),
    .ext_rx_ws(ext_rx_ws), .bclk_o(bclk_o), .tx_ws_o(tx_ws_o), .rx_ws_o(rx_ws_o),
    .clk_oe(clk_oe), .bit_stb(bit_stb), .tx_frame_stb(tx_frame_stb),
    .rx_frame_stb(rx_frame_stb));

  always #2.5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit armed = 1'b0, done = 1'b0;

  // behavioural reference state
  int mc, ms, tf, ts, rf, rs;
  int sb[3], tw[3], rw[3];

  always @(posedge clk) begin
    if (!rst_n) begin
      mc = 0; ms = cfg_mdiv; tf = 0; ts = cfg_tx_div; rf = 0; rs = cfg_rx_div;
      for (int i = 0; i < 3; i++) begin sb[i] = 0; tw[i] = 0; rw[i] = 0; end
      armed = 1'b1;
    end else begin
      bit be, te, re;
      be = (mc == ms);
      te = be && (tf == ts);
      re = be && (rf == rs);
      if (be) begin
        mc = 0;
        if (te) ms = cfg_mdiv;
        if (te) begin tf = 0; ts = cfg_tx_div; end else tf++;
        if (re) begin rf = 0; rs = cfg_rx_div; end else rf++;
      end else mc++;
      sb[2] = sb[1]; sb[1] = sb[0]; sb[0] = int'(ext_bclk ^ cfg_bclk_inv);
      tw[2] = tw[1]; tw[1] = tw[0]; tw[0] = int'(ext_tx_ws);
      rw[2] = rw[1]; rw[1] = rw[0]; rw[0] = int'(ext_rx_ws);
    end
  end

  task automatic chk(string tag, string what, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare every output at each falling edge (clk low here)
  always @(negedge clk) begin
    if (armed && rst_n && !done) begin
      logic e_bclk, e_bit, e_tws, e_tst, e_rws, e_rst, m_bit;
      string bt, ft;
      m_bit = (mc == ms);
      if (cfg_slave) begin
        e_bclk = sb[1][0]; e_bit = sb[1][0] & ~sb[2][0];
        e_tws = tw[1][0]; e_tst = ~tw[1][0] & tw[2][0];
        e_rws = rw[1][0]; e_rst = ~rw[1][0] & rw[2][0];
        bt = cfg_bclk_inv ? "R7" : "R8";
      end else begin
        e_bclk = ((ms == 0) ? 1'b0 : (mc >= (ms + 1) / 2)) ^ cfg_bclk_inv;
        e_bit = m_bit;
        e_tws = (tf >= (ts + 1) / 2); e_tst = m_bit && (tf == ts);
        e_rws = (rf >= (rs + 1) / 2); e_rst = m_bit && (rf == rs);
        bt = cfg_bclk_inv ? "R7" : ((ms == 0) ? "R2" : "R1");
      end
      if (cfg_share == 2'd1) begin e_rws = e_tws; e_rst = e_tst; end
      if (cfg_share == 2'd2) begin e_tws = e_rws; e_tst = e_rst; end
      ft = (cfg_share == 2'd1 || cfg_share == 2'd2) ? "R5" : (cfg_slave ? "R8" : "R3");
      chk(bt, "bclk_o", bclk_o, e_bclk);
      chk(bt, "bit_stb", bit_stb, e_bit);
      chk(ft, "tx_ws_o", tx_ws_o, e_tws);
      chk(ft, "tx_frame_stb", tx_frame_stb, e_tst);
      chk((ft == "R3") ? "R4" : ft, "rx_ws_o", rx_ws_o, e_rws);
      chk((ft == "R3") ? "R4" : ft, "rx_frame_stb", rx_frame_stb, e_rst);
      chk("R9", "clk_oe", clk_oe, ~cfg_slave);
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic slave_run(int n, int half, int frame_bits);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      ext_bclk  = ((i / half) % 2) == 1;
      ext_tx_ws = ((i / (2 * half)) % frame_bits) >= frame_bits / 2;
      ext_rx_ws = ((i / (2 * half)) % (frame_bits / 2)) >= frame_bits / 4;
    end
  endtask

  initial begin
    fork
      begin
        step(3);
        rst_n = 1'b1;
        // R10: right after reset release a fresh period/frame begins
        #1;
        chk("R10", "tx_ws_o after reset", tx_ws_o, 1'b0);
        chk("R10", "bit_stb after reset", bit_stb, 1'b0);
        step(700);                             // R1 R3 R4 default timing
        cfg_tx_div = 8'd7; cfg_rx_div = 8'd20; // R6 mid-frame change
        step(50);
        cfg_mdiv = 8'd1;                       // R6 master change deferred
        step(600);
        cfg_share = 2'd1; step(300);           // R5
        cfg_share = 2'd2; step(300);           // R5
        cfg_share = 2'd3; step(200);           // R4
        cfg_bclk_inv = 1'b1; step(200);        // R7
        cfg_bclk_inv = 1'b0;
        cfg_mdiv = 8'd0; step(200);            // R2 bypass
        for (int i = 0; i < 20; i++) begin
          @(posedge clk); #1.5;
          chk("R2", "bclk_o high phase", bclk_o, 1'b1);
        end
        cfg_bclk_inv = 1'b1; step(40);
        cfg_bclk_inv = 1'b0;
        cfg_mdiv = 8'd4; step(400);
        cfg_slave = 1'b1;                      // R8 R9
        slave_run(800, 3, 8);
        cfg_share = 2'd1; slave_run(300, 2, 8);
        cfg_bclk_inv = 1'b1; cfg_share = 2'd0; slave_run(400, 3, 8); // R7
        cfg_slave = 1'b0; cfg_bclk_inv = 1'b0;
        step(300);
        rst_n = 1'b0; cfg_mdiv = 8'd2; cfg_tx_div = 8'd5; step(2); // R10
        rst_n = 1'b1;
        #1;
        chk("R10", "tx_ws_o after reset 2", tx_ws_o, 1'b0);
        chk("R10", "clk_oe after reset", clk_oe, 1'b1);
        step(400);
        done = 1'b1;
      end
      begin
        #(200000 * 5);
        if (!done) begin
          n_cmp++; n_bad++;
          $display("FAIL watchdog: actual hung expected done");
          done = 1'b1;
        end
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule